// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-mode control and status registers of a small RISC-V core and runs the CSR read-modify-write instructions. In each cycle where `req_valid` is high, the core presents the CSR address, an operation code, the rs1 register value, the 5-bit immediate field and the PC. The block returns the current contents of the addressed CSR on `rd_data`, combinationally, for write-back to rd. The updated value is stored at the next rising clock edge. Reading and updating therefore happen as a single step.

When the request is an environment call, the block raises `trap_taken` in the same cycle and drives `trap_pc` with the trap base register, so that the core's next PC is the handler address. At the same clock edge it records the faulting PC and cause code 11. There is no back-pressure. Every valid request is accepted in the cycle in which it appears, so no ready signal is needed.

CSR map. Addresses are the architectural ones, because software decodes them:

| CSR | Address | Reset value | Writable bits |
|---|---|---|---|
| status | 0x300 | 0 | 0x00000088 |
| trap base | 0x305 | 0x00000100 | 0xFFFFFFFC |
| scratch | 0x340 | 0 | all |
| exception PC | 0x341 | 0 | 0xFFFFFFFC |
| cause | 0x342 | 0 | 0x8000000F |

Top module: `mcsr_trap_unit`

## Requirements
- R1: While `req_valid` is high, `rd_data` equals the value the addressed CSR held before the current cycle's update. Any change becomes visible from the next clock edge onward.
- R2: Op code 1 (register write) stores the rs1 value, ANDed with that CSR's writable-bit mask.
- R3: Op code 2 (register set) stores the old value ORed with rs1. A zero rs1 leaves the CSR unchanged.
- R4: Op code 3 (register clear) stores the old value ANDed with the inverted rs1. A zero rs1 leaves the CSR unchanged.
- R5: Op codes 5, 6 and 7 behave like codes 1, 2 and 3, except that the operand is `req_zimm` zero-extended to 32 bits.
- R6: A valid request with `req_ecall` high drives `trap_taken` high in the same cycle, with `trap_pc` equal to the current trap base value.
- R7: After an ecall, the exception PC holds `req_pc` with bits 1:0 cleared, and the cause holds 11. Any CSR op in the same request is discarded.
- R8: A valid request to any address other than the five listed returns 0 on `rd_data`, and its write is ignored.
- R9: Only the writable-bit mask of each CSR can change. All other bits read as zero; for example, bits 1:0 of the trap base always read 0.
- R10: With `req_valid` low, `rd_data` is 0, `trap_taken` is 0 and no CSR changes. Op codes 0 and 4 read the CSR without writing it.
- R11: After reset, the trap base reads 0x00000100 and every other CSR reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0/4 read only, 1 write, 2 set, 3 clear, 5/6/7 immediate forms) |
| req_addr | input | 12 | CSR address |
| req_rs1_val | input | 32 | Register operand |
| req_zimm | input | 5 | Immediate operand |
| req_pc | input | 32 | PC of the current instruction |
| req_ecall | input | 1 | Request is an environment call |
| rd_data | output | 32 | Old CSR value for rd |
| trap_taken | output | 1 | Redirect the PC this cycle |
| trap_pc | output | 32 | Redirect target (trap base) |

## Verification
A corrupted CSR shows up on `rd_data` at the first read of that address after the bad update, which can come as early as the very next cycle. A corrupted trap base shows up at once on `trap_pc` in the same cycle as the next ecall. Bad mask handling or a missed zero-operand suppression shows up as a wrong value on the following read of the affected CSR. The random mix reads back each CSR often, so such faults surface within a few cycles of being introduced.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;
  localparam int ZIMM_W = 5;
  localparam int NCSR   = 5;

  localparam int IDX_STATUS  = 0;
  localparam int IDX_TBASE   = 1;
  localparam int IDX_SCRATCH = 2;
  localparam int IDX_EPC     = 3;
  localparam int IDX_CAUSE   = 4;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WR     = 3'd1,
    OP_SET    = 3'd2,
    OP_CLR    = 3'd3,
    OP_READ_I = 3'd4,
    OP_WR_I   = 3'd5,
    OP_SET_I  = 3'd6,
    OP_CLR_I  = 3'd7
  } csr_op_e;

  localparam logic [ADDR_W-1:0] CSR_ADDR [NCSR] = '{
    12'h300, 12'h305, 12'h340, 12'h341, 12'h342
  };

  localparam logic [XLEN-1:0] CSR_MASK [NCSR] = '{
    32'h0000_0088, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h8000_000F
  };

  localparam logic [XLEN-1:0] CAUSE_ECALL_M = 32'd11;

  typedef logic [NCSR-1:0][XLEN-1:0] csr_state_t;
endpackage

// File: rtl/mcsr_operand.sv
module mcsr_operand
  import mcsr_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [ZIMM_W-1:0] zimm,
  input  logic [XLEN-1:0]   old_val,
  output logic [XLEN-1:0]   new_val,
  output logic              wr_req
);
  logic [XLEN-1:0] operand;
  logic            operand_zero;

  always_comb begin
    operand      = op[2] ? {{(XLEN-ZIMM_W){1'b0}}, zimm} : rs1_val;
    operand_zero = (operand == '0);
    unique case (op[1:0])
      2'd1:    new_val = operand;
      2'd2:    new_val = old_val | operand;
      2'd3:    new_val = old_val & ~operand;
      default: new_val = old_val;
    endcase
    case (op[1:0])
      2'd1:       wr_req = 1'b1;
      2'd2, 2'd3: wr_req = !operand_zero;
      default:    wr_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_TVEC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_val,
  input  logic              trap_en,
  input  logic [XLEN-1:0]   trap_epc,
  output logic [XLEN-1:0]   rd_val,
  output logic              hit,
  output logic [XLEN-1:0]   tbase,
  output csr_state_t        state
);
  logic [NCSR-1:0] sel;

  always_comb begin
    rd_val = '0;
    hit    = 1'b0;
    for (int i = 0; i < NCSR; i++) begin
      sel[i] = (addr == CSR_ADDR[i]);
      if (sel[i]) begin
        rd_val = state[i];
        hit    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCSR; g++) begin : g_csr
    localparam logic [XLEN-1:0] RST = (g == IDX_TBASE) ? (RESET_TVEC & CSR_MASK[g]) : '0;
    logic            trap_load;
    logic [XLEN-1:0] trap_val;

    if (g == IDX_EPC) begin : g_epc
      assign trap_load = trap_en;
      assign trap_val  = trap_epc;
    end else if (g == IDX_CAUSE) begin : g_cause
      assign trap_load = trap_en;
      assign trap_val  = CAUSE_ECALL_M;
    end else begin : g_plain
      assign trap_load = 1'b0;
      assign trap_val  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        state[g] <= RST;
      else if (trap_load)
        state[g] <= trap_val & CSR_MASK[g];
      else if (wr_en && sel[g])
        state[g] <= wr_val & CSR_MASK[g];
    end
  end

  assign tbase = state[IDX_TBASE];
endmodule

// File: rtl/mcsr_trap_ctrl.sv
module mcsr_trap_ctrl
  import mcsr_pkg::*;
(
  input  logic            req_valid,
  input  logic            req_ecall,
  input  logic [XLEN-1:0] tbase,
  output logic            trap_taken,
  output logic [XLEN-1:0] trap_pc,
  output logic            op_gate
);
  always_comb begin
    trap_taken = req_valid && req_ecall;
    trap_pc    = tbase;
    op_gate    = req_valid && !req_ecall;
  end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter logic [31:0] RESET_TVEC = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_rs1_val,
  input  logic [4:0]  req_zimm,
  input  logic [31:0] req_pc,
  input  logic        req_ecall,
  output logic [31:0] rd_data,
  output logic        trap_taken,
  output logic [31:0] trap_pc
);
  logic [XLEN-1:0] old_val, new_val, tbase;
  logic            hit, wr_req, op_gate, trap_en;
  csr_state_t      csr_state;

  mcsr_operand u_operand (
    .op(req_op), .rs1_val(req_rs1_val), .zimm(req_zimm),
    .old_val(old_val), .new_val(new_val), .wr_req(wr_req)
  );

  mcsr_trap_ctrl u_trap (
    .req_valid(req_valid), .req_ecall(req_ecall), .tbase(tbase),
    .trap_taken(trap_taken), .trap_pc(trap_pc), .op_gate(op_gate)
  );

  assign trap_en = trap_taken;

  mcsr_file #(.RESET_TVEC(RESET_TVEC)) u_file (
    .clk(clk), .rst_n(rst_n), .addr(req_addr),
    .wr_en(op_gate && wr_req), .wr_val(new_val),
    .trap_en(trap_en), .trap_epc(req_pc),
    .rd_val(old_val), .hit(hit), .tbase(tbase), .state(csr_state)
  );

  assign rd_data = (req_valid && hit) ? old_val : '0;
endmodule

// File: rtl/mcsr_trap_checker.sv
module mcsr_trap_checker
  import mcsr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_op,
  input logic [11:0] req_addr,
  input logic [31:0] req_rs1_val,
  input logic [31:0] req_pc,
  input logic        req_ecall,
  input logic [31:0] rd_data,
  input logic        trap_taken,
  input logic [31:0] trap_pc,
  input csr_state_t  csr_state
);
  logic known;
  logic csr_op;
  always_comb begin
    known = 1'b0;
    for (int i = 0; i < NCSR; i++) if (req_addr == CSR_ADDR[i]) known = 1'b1;
    csr_op = req_valid && !req_ecall;
  end

  AST_SCRATCH_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op && req_op == 3'd1 && req_addr == 12'h340) |=>
      ((req_valid && req_addr == 12'h340) |-> rd_data == $past(req_rs1_val))); // R2

  AST_TBASE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op && req_op == 3'd1 && req_addr == 12'h305) |=>
      trap_pc == ($past(req_rs1_val) & 32'hFFFF_FFFC)); // R6

  AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ecall) |=> csr_state[IDX_CAUSE] == 32'd11); // R7

  AST_ECALL_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ecall) |=> csr_state[IDX_EPC] == ($past(req_pc) & 32'hFFFF_FFFC)); // R7

  AST_ZERO_SETCLR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op && (req_op == 3'd2 || req_op == 3'd3) && req_rs1_val == 32'd0) |=>
      $stable(csr_state)); // R3

  AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !known) |-> rd_data == 32'd0); // R8

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op && !known) |=> $stable(csr_state)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!trap_taken && rd_data == 32'd0)); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(csr_state)); // R10

  AST_TBASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pc[1:0] == 2'b00); // R9
endmodule

bind mcsr_trap_unit mcsr_trap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_rs1_val(req_rs1_val), .req_pc(req_pc),
  .req_ecall(req_ecall), .rd_data(rd_data), .trap_taken(trap_taken),
  .trap_pc(trap_pc), .csr_state(csr_state)
);

// File: tb/tb_mcsr_trap_unit.sv
module tb_mcsr_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [11:0] req_addr = 12'd0;
  logic [31:0] req_rs1_val = 32'd0;
  logic [4:0]  req_zimm = 5'd0;
  logic [31:0] req_pc = 32'd0;
  logic        req_ecall = 1'b0;
  logic [31:0] rd_data;
  logic        trap_taken;
  logic [31:0] trap_pc;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m [5];
  localparam logic [11:0] A_ST = 12'h300, A_TB = 12'h305, A_SC = 12'h340,
                          A_EP = 12'h341, A_CA = 12'h342;

  always #5 clk = ~clk;

  mcsr_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_rs1_val(req_rs1_val), .req_zimm(req_zimm),
    .req_pc(req_pc), .req_ecall(req_ecall), .rd_data(rd_data),
    .trap_taken(trap_taken), .trap_pc(trap_pc)
  );

  function automatic int idx_of(logic [11:0] a);
    case (a)
      A_ST: return 0;
      A_TB: return 1;
      A_SC: return 2;
      A_EP: return 3;
      A_CA: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(int i);
    case (i)
      0: return 32'h0000_0088;
      1: return 32'hFFFF_FFFC;
      3: return 32'hFFFF_FFFC;
      4: return 32'h8000_000F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] op, input logic [11:0] a,
                       input logic [31:0] rs1, input logic [4:0] zi,
                       input logic [31:0] pc, input logic ec, input string tag);
    int i;
    logic [31:0] opnd, nv, exp_rd;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_rs1_val = rs1;
    req_zimm = zi; req_pc = pc; req_ecall = ec;
    #2;
    i = idx_of(a);
    exp_rd = (v && i >= 0) ? m[i] : 32'd0;
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "trap_taken", {31'd0, trap_taken}, {31'd0, v && ec});
    if (v && ec) check(tag, "trap_pc", trap_pc, m[1]);
    if (v && ec) begin
      m[3] = pc & 32'hFFFF_FFFC;
      m[4] = 32'd11;
    end else if (v && i >= 0 && op[1:0] != 2'd0) begin
      opnd = op[2] ? {27'd0, zi} : rs1;
      case (op[1:0])
        2'd1: nv = opnd;
        2'd2: nv = m[i] | opnd;
        default: nv = m[i] & ~opnd;
      endcase
      if (op[1:0] == 2'd1 || opnd != 32'd0) m[i] = nv & mask_of(i);
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    apply(1'b1, 3'd0, a, 32'd0, 5'd0, 32'd0, 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m[0] = 0; m[1] = 32'h100; m[2] = 0; m[3] = 0; m[4] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset values
    rd(A_TB, "R11"); rd(A_ST, "R11"); rd(A_SC, "R11"); rd(A_EP, "R11"); rd(A_CA, "R11");
    // R10 idle
    apply(1'b0, 3'd1, A_SC, 32'hDEAD, 5'd0, 32'd0, 1'b0, "R10");
    rd(A_SC, "R10");
    apply(1'b1, 3'd4, A_SC, 32'h1, 5'h1F, 32'd0, 1'b0, "R10");
    rd(A_SC, "R10");
    // R2, R1 write returns old
    apply(1'b1, 3'd1, A_SC, 32'hCAFE_F00D, 5'd0, 32'd0, 1'b0, "R2");
    apply(1'b1, 3'd1, A_SC, 32'h1234_5678, 5'd0, 32'd0, 1'b0, "R1");
    rd(A_SC, "R1");
    // R3 set, zero set
    apply(1'b1, 3'd2, A_SC, 32'h0000_0F00, 5'd0, 32'd0, 1'b0, "R3");
    apply(1'b1, 3'd2, A_SC, 32'd0, 5'd0, 32'd0, 1'b0, "R3");
    rd(A_SC, "R3");
    // R4 clear
    apply(1'b1, 3'd3, A_SC, 32'h1000_0008, 5'd0, 32'd0, 1'b0, "R4");
    apply(1'b1, 3'd3, A_SC, 32'd0, 5'd0, 32'd0, 1'b0, "R4");
    rd(A_SC, "R4");
    // R5 immediate forms
    apply(1'b1, 3'd5, A_SC, 32'hFFFF_FFFF, 5'h15, 32'd0, 1'b0, "R5");
    apply(1'b1, 3'd6, A_SC, 32'h0, 5'h0A, 32'd0, 1'b0, "R5");
    apply(1'b1, 3'd7, A_SC, 32'hFFFF_FFFF, 5'h01, 32'd0, 1'b0, "R5");
    rd(A_SC, "R5");
    // R9 masks
    apply(1'b1, 3'd1, A_ST, 32'hFFFF_FFFF, 5'd0, 32'd0, 1'b0, "R9");
    rd(A_ST, "R9");
    apply(1'b1, 3'd1, A_TB, 32'h8000_0003, 5'd0, 32'd0, 1'b0, "R9");
    rd(A_TB, "R9");
    // R6, R7 ecall
    apply(1'b1, 3'd0, 12'h000, 32'd0, 5'd0, 32'h0000_0123, 1'b1, "R6");
    rd(A_EP, "R7"); rd(A_CA, "R7");
    apply(1'b1, 3'd1, A_SC, 32'h5555_5555, 5'd0, 32'h0000_0400, 1'b1, "R7");
    rd(A_SC, "R7"); rd(A_EP, "R7");
    // R8 unimplemented
    apply(1'b1, 3'd1, 12'h301, 32'hFFFF_FFFF, 5'd0, 32'd0, 1'b0, "R8");
    rd(12'h301, "R8");
    apply(1'b1, 3'd6, 12'h7C0, 32'd0, 5'h1F, 32'd0, 1'b0, "R8");
    rd(A_SC, "R8");
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [11:0] a;
      logic [2:0] op;
      logic ec, v;
      int r;
      r = $urandom_range(0, 7);
      case (r)
        0: a = A_ST; 1: a = A_TB; 2: a = A_SC; 3: a = A_EP; 4: a = A_CA;
        5: a = 12'h343; 6: a = 12'h000;
        default: a = A_SC;
      endcase
      op = 3'($urandom_range(0, 7));
      ec = ($urandom_range(0, 15) == 0);
      v  = ($urandom_range(0, 9) != 0);
      apply(v, op, a, ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom,
            5'($urandom), $urandom, ec,
            !v ? "R10" : ec ? "R6" : (idx_of(a) < 0) ? "R8" : op[2] ? "R5" :
            (op[1:0] == 2'd1) ? "R2" : (op[1:0] == 2'd2) ? "R3" :
            (op[1:0] == 2'd3) ? "R4" : "R1");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule